// File: doc/BRIEF.md
# Carry-skip adder/subtractor

This block is a purely combinational two's-complement adder/subtractor. Each operand is split into ripple-carry groups of a fixed number of bits. Every group has a bypass: when every bit of the group would pass an incoming carry straight through, the group's carry-out is taken directly from its carry-in. In that case the carry does not travel the group's internal chain. The default is 16 bits in four groups of 4 bits. Group 0 holds the lowest bits.

An optional second bypass level spans several neighbouring groups. It is controlled by the AND of their group-propagate flags, so a carry can jump over all of them in one step. A select input chooses the operation. For addition, the sum is A plus B plus the carry-in. For subtraction, B is inverted bit by bit and the low-order carry is forced high. The per-group propagate flags are brought out so that the behaviour of the skip path can be observed.

The width must be a whole multiple of the group size. When the second level is enabled, the number of groups must be a whole multiple of the second-level span. Both conditions are checked at elaboration.

Top module: `carry_skip_addsub`

## Requirements
- R1: With sub_mode=0, {carry_out, sum} equals op_a + op_b + carry_in, computed at WIDTH+1 bits.
- R2: With sub_mode=1, sum equals (op_a - op_b) mod 2^WIDTH. carry_out equals bit WIDTH of op_a + ~op_b + 1, which is 1 exactly when op_a >= op_b as unsigned values.
- R3: With sub_mode=1, carry_in has no effect on sum or carry_out.
- R4: Bit g of grp_prop is 1 exactly when every bit of op_a ^ (sub_mode ? ~op_b : op_b) within bits g*GROUP to g*GROUP+GROUP-1 is 1. Bit 0 covers the lowest group.
- R5: Under an all-propagate pattern (op_a=16'hFFFF, op_b=0, carry_in=1, addition), sum is 0, carry_out is 1 and grp_prop is all ones.
- R6: A carry generated in bit 0 reaches carry_out across groups that propagate. For op_a=16'hFFFF, op_b=16'h0001 in addition: sum is 0, carry_out is 1 and grp_prop is 4'b1110.
- R7: A kill inside a group stops the carry. For op_a=16'h0F0F, op_b=16'h0001, carry_in=0 in addition: sum is 16'h0F10 and carry_out is 0.
- R8: When a whole second-level span propagates, the carry skips the span correctly. For op_a=16'h00FF, op_b=0, carry_in=1 in addition: sum is 16'h0100, carry_out is 0 and grp_prop is 4'b0011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand (the subtrahend in subtract mode) |
| carry_in | input | 1 | Carry into bit 0 in add mode; ignored in subtract mode |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| sum | output | WIDTH | Result |
| carry_out | output | 1 | Carry out of the top bit (no-borrow flag when subtracting) |
| grp_prop | output | WIDTH/GROUP | Per-group propagate flags, bit 0 = lowest group |

## Verification
Random operand pairs in both modes show that the skip muxes never change the arithmetic result compared with a plain wide sum. In subtract mode, the same pairs are applied with carry_in at both values to show that it is ignored. Directed patterns then force the carry onto specific paths. An all-propagate word sends the carry-in through every bypass. A carry generated in bit 0 travels across three skipping groups. A killed bit stops the carry halfway up. An 8-bit all-propagate span exercises the second-level bypass. Each of these patterns also checks the propagate flags that steer the muxes.

// File: rtl/csa_pkg.sv
// Package: shared types for the carry-skip adder/subtractor.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package csa_pkg;

    // Per-bit carry status pair: generate and propagate.
    typedef struct packed {
        logic gen;
        logic prp;
    } bit_stat_t;

    // Carry status of a single bit position.
    function automatic bit_stat_t bit_status(input logic a, input logic b);
        bit_stat_t r;
        r.gen = a & b;
        r.prp = a ^ b;
        return r;
    endfunction

endpackage

// File: rtl/csa_operand.sv
// Module: csa_operand
// Conditions the second operand for subtraction and forms the per-bit
// generate/propagate vectors. It also selects the low-order carry.
// Assumes: sub_mode is static for the duration of one evaluation.
module csa_operand #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] gen_v,
    output logic [WIDTH-1:0] prp_v,
    output logic             carry0
);
    import csa_pkg::*;

    logic [WIDTH-1:0] b_eff;

    // Invert the subtrahend bitwise with the mode select.
    assign b_eff  = op_b ^ {WIDTH{sub_mode}};

    // Subtraction forces a carry of one into bit 0.
    assign carry0 = sub_mode ? 1'b1 : carry_in;

    // Per-bit generate and propagate.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            bit_stat_t st;
            st       = bit_status(op_a[i], b_eff[i]);
            gen_v[i] = st.gen;
            prp_v[i] = st.prp;
        end
    end

    // R3: in subtract mode the bit-0 carry is always one, whatever carry_in is.
    always_comb begin
        if (sub_mode) assert_sub_carry_R3: assert (carry0 == 1'b1);
    end

endmodule

// File: rtl/csa_group.sv
// Module: csa_group
// One ripple-carry group. It has a bypass mux on its carry-out that is
// steered by the AND of its propagate bits.
// Assumes: gen and prp come from the same bit pair (never both high).
module csa_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] gen,
    input  logic [GW-1:0] prp,
    input  logic          ci,
    output logic [GW-1:0] s,
    output logic          co,
    output logic          bp
);
    logic rip_co;

    // Ripple the carry through the group and form the sum bits.
    always_comb begin
        logic c;
        c = ci;
        for (int i = 0; i < GW; i++) begin
            s[i] = prp[i] ^ c;
            c    = gen[i] | (prp[i] & c);
        end
        rip_co = c;
    end

    // Group propagate flag.
    assign bp = &prp;

    // Bypass mux: pass the carry-in straight on when the whole group propagates.
    assign co = bp ? ci : rip_co;

    // R4/R6: the skip path must agree with the rippled carry.
    always_comb begin
        assert_skip_equals_ripple_R6: assert (co == rip_co);
        if (bp) assert_prop_passes_carry_R4: assert (s == {GW{~ci}});
    end

endmodule

// File: rtl/csa_skip2.sv
// Module: csa_skip2
// Second-level bypass over SPAN adjacent groups. It is steered by the AND
// of their first-level propagate flags.
// Assumes: last_co is the first-level carry-out of the top group in the span.
module csa_skip2 #(
    parameter int SPAN = 2
) (
    input  logic [SPAN-1:0] grp_bp,
    input  logic            span_ci,
    input  logic            last_co,
    output logic            span_co
);
    // Jump over the whole span when every group in it propagates.
    assign span_co = (&grp_bp) ? span_ci : last_co;

    // R8: the second-level jump must agree with the first-level chain.
    always_comb begin
        assert_span_skip_R8: assert (span_co == last_co);
    end

endmodule

// File: rtl/carry_skip_addsub.sv
// Module: carry_skip_addsub
// Combinational carry-skip adder/subtractor. It is built from GROUP-bit
// ripple groups, each with a bypass, plus an optional second bypass level
// over SPAN groups.
// Assumes: WIDTH is a multiple of GROUP, and WIDTH/GROUP is a multiple of
// SPAN when SKIP2 is set. No clock or reset: the block is purely combinational.
module carry_skip_addsub #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4,
    parameter bit SKIP2 = 1'b1,
    parameter int SPAN  = 2
) (
    input  logic [WIDTH-1:0]       op_a,
    input  logic [WIDTH-1:0]       op_b,
    input  logic                   carry_in,
    input  logic                   sub_mode,
    output logic [WIDTH-1:0]       sum,
    output logic                   carry_out,
    output logic [WIDTH/GROUP-1:0] grp_prop
);
    localparam int NG = WIDTH / GROUP;

    // Elaboration-time checks on the configuration.
    if (WIDTH % GROUP != 0) begin : g_bad_width
        $error("WIDTH must be a multiple of GROUP");
    end
    if (SKIP2 && (NG % SPAN != 0)) begin : g_bad_span
        $error("group count must be a multiple of SPAN");
    end

    logic [WIDTH-1:0] gen_v;
    logic [WIDTH-1:0] prp_v;
    logic             carry0;
    logic [NG:0]      gc;
    logic [NG-1:0]    gco;

    csa_operand #(.WIDTH(WIDTH)) u_operand (
        .op_a     (op_a),
        .op_b     (op_b),
        .carry_in (carry_in),
        .sub_mode (sub_mode),
        .gen_v    (gen_v),
        .prp_v    (prp_v),
        .carry0   (carry0)
    );

    assign gc[0] = carry0;

    // One ripple group per GROUP bits, chained through gc.
    for (genvar gi = 0; gi < NG; gi++) begin : g_grp
        csa_group #(.GW(GROUP)) u_group (
            .gen (gen_v[gi*GROUP +: GROUP]),
            .prp (prp_v[gi*GROUP +: GROUP]),
            .ci  (gc[gi]),
            .s   (sum[gi*GROUP +: GROUP]),
            .co  (gco[gi]),
            .bp  (grp_prop[gi])
        );
    end

    // Carry into the next group: the second-level output at span boundaries.
    if (SKIP2) begin : g_lvl2
        localparam int NS = NG / SPAN;
        logic [NS-1:0] sco;
        for (genvar si = 0; si < NS; si++) begin : g_span
            csa_skip2 #(.SPAN(SPAN)) u_skip2 (
                .grp_bp  (grp_prop[si*SPAN +: SPAN]),
                .span_ci (gc[si*SPAN]),
                .last_co (gco[si*SPAN+SPAN-1]),
                .span_co (sco[si])
            );
        end
        for (genvar gi = 0; gi < NG; gi++) begin : g_link
            if ((gi + 1) % SPAN == 0) begin : g_span_end
                assign gc[gi+1] = sco[(gi+1)/SPAN-1];
            end else begin : g_inner
                assign gc[gi+1] = gco[gi];
            end
        end
    end else begin : g_lvl1
        assign gc[NG:1] = gco;
    end

    assign carry_out = gc[NG];

    // R1/R2: result matches a plain wide sum of the conditioned operands.
    always_comb begin
        if (!sub_mode)
            assert_add_result_R1: assert ({carry_out, sum} ==
                ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
        else
            assert_sub_result_R2: assert ({carry_out, sum} ==
                ({1'b0, op_a} + {1'b0, ~op_b} + {{WIDTH{1'b0}}, 1'b1}));
    end

endmodule

// File: tb/carry_skip_addsub_tb.sv
// Bench for carry_skip_addsub: directed scenarios plus random vectors.
module carry_skip_addsub_tb;
    localparam int W  = 16;
    localparam int GS = 4;
    localparam int NG = W / GS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic          carry_in = 1'b0, sub_mode = 1'b0;
    logic [W-1:0]  sum;
    logic          carry_out;
    logic [NG-1:0] grp_prop;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    carry_skip_addsub #(.WIDTH(W), .GROUP(GS), .SKIP2(1'b1), .SPAN(2)) u_dut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sub_mode(sub_mode),
        .sum(sum), .carry_out(carry_out), .grp_prop(grp_prop)
    );

    // Record one comparison.
    task automatic check(input string req, input string what,
                         input logic [W:0] act, input logic [W:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one vector on the falling edge and sample 1 ns later.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input logic sb);
        @(negedge clk);
        op_a = a; op_b = b; carry_in = ci; sub_mode = sb;
        #1;
    endtask

    // Expected flags from the rule in the requirement.
    function automatic logic [NG-1:0] exp_prop(input logic [W-1:0] a,
                                               input logic [W-1:0] b, input logic sb);
        logic [W-1:0] pv;
        logic [NG-1:0] r;
        pv = a ^ (sb ? ~b : b);
        for (int g = 0; g < NG; g++) r[g] = &pv[g*GS +: GS];
        return r;
    endfunction

    // Check a vector against the arithmetic model.
    task automatic vec(input string req, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic ci, input logic sb);
        logic [W:0] e;
        apply(a, b, ci, sb);
        if (sb) e = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        else    e = {1'b0, a} + {1'b0, b} + (W+1)'(ci);
        check(req, "sum/carry", {carry_out, sum}, e);
        check("R4", "grp_prop", (W+1)'(grp_prop), (W+1)'(exp_prop(a, b, sb)));
    endtask

    // Scenario: zero inputs right after start-up.
    task automatic t_reset;
        apply('0, '0, 1'b0, 1'b0);
        check("R1", "zero inputs", {carry_out, sum}, '0);
        check("R4", "zero prop", (W+1)'(grp_prop), '0);
    endtask

    // Scenario: random additions.
    task automatic t_rand_add;
        for (int i = 0; i < 300; i++)
            vec("R1", W'($urandom), W'($urandom), 1'($urandom), 1'b0);
    endtask

    // Scenario: random subtractions, with carry_in both ways.
    task automatic t_rand_sub;
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a, b;
            logic [W:0] r0;
            a = W'($urandom); b = W'($urandom);
            vec("R2", a, b, 1'b0, 1'b1);
            r0 = {carry_out, sum};
            apply(a, b, 1'b1, 1'b1);
            check("R3", "carry_in ignored", {carry_out, sum}, r0);
        end
        vec("R2", 16'h1234, 16'h1234, 1'b0, 1'b1);
        vec("R2", 16'h0000, 16'h0001, 1'b1, 1'b1);
    endtask

    // Scenario: the whole word propagates.
    task automatic t_all_prop;
        apply(16'hFFFF, 16'h0000, 1'b1, 1'b0);
        check("R5", "sum/carry", {carry_out, sum}, {1'b1, 16'h0000});
        check("R5", "grp_prop", (W+1)'(grp_prop), (W+1)'(4'b1111));
        apply(16'hFFFF, 16'h0000, 1'b0, 1'b0);
        check("R5", "cin=0", {carry_out, sum}, {1'b0, 16'hFFFF});
    endtask

    // Scenario: bit 0 generates and three groups skip.
    task automatic t_gen_bit0;
        apply(16'hFFFF, 16'h0001, 1'b0, 1'b0);
        check("R6", "sum/carry", {carry_out, sum}, {1'b1, 16'h0000});
        check("R6", "grp_prop", (W+1)'(grp_prop), (W+1)'(4'b1110));
    endtask

    // Scenario: a kill stops the carry.
    task automatic t_kill;
        apply(16'h0F0F, 16'h0001, 1'b0, 1'b0);
        check("R7", "sum/carry", {carry_out, sum}, {1'b0, 16'h0F10});
    endtask

    // Scenario: an 8-bit second-level span propagates.
    task automatic t_span;
        apply(16'h00FF, 16'h0000, 1'b1, 1'b0);
        check("R8", "sum/carry", {carry_out, sum}, {1'b0, 16'h0100});
        check("R8", "grp_prop", (W+1)'(grp_prop), (W+1)'(4'b0011));
        apply(16'hFF00, 16'h00FF, 1'b1, 1'b0);
        check("R8", "upper span", {carry_out, sum}, {1'b1, 16'h0000});
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Main sequence.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rand_add();
        t_rand_sub();
        t_all_prop();
        t_gen_bit0();
        t_kill();
        t_span();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule